// File: doc/BRIEF.md
# Circular Audio DMA Address Engine

This block generates memory addresses for a streaming audio channel. It moves data in fixed-size bursts. Each burst is requested from a memory arbiter through a simple request/grant handshake. Bursts walk a ring buffer: the pointer starts at a base address and steps one burst at a time. The last-burst register holds the address where the final burst of the ring begins, and after that burst the pointer returns to the base. A new request is raised when the occupancy of the local FIFO falls to a programmable threshold. The threshold is coded in bursts minus one.

A burst counter raises a period event after a programmed number of completed bursts and then starts counting again. A second event marks each return to the base address. Each event has an enable, a sticky status flag and a clear bit. The clear bit is level-sensitive: it holds the flag at zero until software writes the bit back to zero. A selectable status word reports the live pointer, the burst count within the current period, or the FIFO level.

Software programs the addresses while the engine is disabled. An optional initial address can make the first pass begin partway into the ring. Clearing the enable bit pauses the engine. Setting it again resumes from the same burst, unless an address register was written in between.

Top module: `ring_dma_engine`

## Requirements
- R1: After reset, `mem_req_o` and `irq_o` are low, the status word (word 6) reads 0, and the pointer reported by word 7 (select 0) reads 0.
- R2: Each grant of a pending request completes one burst. The next request then carries the pointer advanced by 8 bytes, unless the completed burst was at the last-burst address.
- R3: The burst after the one at the last-burst address (word 3) is requested at the base address (word 2). That completion sets status bit 1 (ring wrap) if enable bit 9 of word 0 is set.
- R4: With word 4 holding P (nonzero), status bit 0 (period) is set on every P-th completed burst, and the count then restarts from zero.
- R5: While enabled and idle, a request is raised only when `fifo_level_i` is at most (C+1)*8 bytes, where C is the threshold code in bits [23:16] of word 0. A code of 0 means 8 bytes.
- R6: Clearing enable bit 0 of word 0 drops `mem_req_o` and stops the pointer. Setting the bit again without writing word 2 or word 5 resumes at the same address.
- R7: While clear bit i of word 1 (bit 0 period, bit 1 wrap) is 1, status bit i stays 0 even when events occur. After the bit is written back to 0, new events set the flag again.
- R8: An event whose enable bit in word 0 (bit 8 period, bit 9 wrap) is 0 never sets its status bit. `irq_o` is the OR of the status bits.
- R9: Word 7 reports a value picked by bits [5:4] of word 1: 0 gives the current burst address, 1 gives the bursts completed in the current period, and 2 gives `fifo_level_i`.
- R10: Once word 5 (initial address) has been written, a reload while disabled sets the pointer to that address. Later wraps still return to the base in word 2.
- R11: A pending request keeps `mem_req_o` high and `mem_addr_o` stable until it is granted or the engine is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Byte address of the register, word aligned |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Read data for `reg_addr_i` (combinational) |
| fifo_level_i | input | LVL_W | Current FIFO occupancy in bytes |
| mem_req_o | output | 1 | Burst request |
| mem_addr_o | output | AW | Start address of the requested burst |
| mem_gnt_i | input | 1 | Grant; completes the pending burst |
| irq_o | output | 1 | Interrupt, OR of the status flags |

## Verification
The bench drives the ring through its last-burst address and back to the base. A design with an off-by-one finish compare would either skip the final burst or fetch one burst past it. The period count is checked across a wrap and against the count read back. A design that fails to restart the count would raise the period flag at the wrong burst. The level-sensitive clear is held through several events that would otherwise set the flag. An edge-style clear would let those events through. Pause/resume and the initial-address reload are checked by the first address requested after re-enable. A design that reloads on every enable, or ignores the initial address, would request the wrong address.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  localparam int NUM_IRQ  = 2;
  localparam int IRQ_PER  = 0;
  localparam int IRQ_WRAP = 1;
  localparam int THR_W    = 8;

  typedef enum logic [2:0] {
    RG_CTRL_A = 3'd0,
    RG_CTRL_B = 3'd1,
    RG_BASE   = 3'd2,
    RG_LAST   = 3'd3,
    RG_PERIOD = 3'd4,
    RG_INIT   = 3'd5,
    RG_STAT_A = 3'd6,
    RG_STAT_B = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    PSEL_ADDR  = 2'd0,
    PSEL_COUNT = 2'd1,
    PSEL_LEVEL = 2'd2,
    PSEL_NONE  = 2'd3
  } ptr_sel_e;

  typedef struct packed {
    logic               dma_en;
    logic [NUM_IRQ-1:0] irq_en;
    logic [NUM_IRQ-1:0] irq_clr;
    logic [THR_W-1:0]   thr_code;
    ptr_sel_e           sel;
    logic               init_valid;
  } ctl_t;
endpackage

// File: rtl/ring_dma_regs.sv
module ring_dma_regs
  import ring_dma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int REG_AW = 5,
  parameter int CNT_W  = 16,
  parameter int LVL_W  = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [REG_AW-1:0]  addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic [AW-1:0]      cur_addr_i,
  input  logic [CNT_W-1:0]   cur_cnt_i,
  input  logic [NUM_IRQ-1:0] status_i,
  input  logic [LVL_W-1:0]   level_i,
  output ctl_t               ctl_o,
  output logic [AW-1:0]      base_o,
  output logic [AW-1:0]      last_o,
  output logic [AW-1:0]      init_o,
  output logic [CNT_W-1:0]   period_o,
  output logic               arm_o
);
  reg_idx_e idx;
  assign idx = reg_idx_e'(addr_i[2 +: 3]);

  // base or initial address written: pointer reloads at next idle cycle
  assign arm_o = we_i && (idx == RG_BASE || idx == RG_INIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o    <= '0;
      base_o   <= '0;
      last_o   <= '0;
      init_o   <= '0;
      period_o <= '0;
    end else if (we_i) begin
      unique case (idx)
        RG_CTRL_A: begin
          ctl_o.dma_en   <= wdata_i[0];
          ctl_o.irq_en   <= wdata_i[8 +: NUM_IRQ];
          ctl_o.thr_code <= wdata_i[16 +: THR_W];
        end
        RG_CTRL_B: begin
          ctl_o.irq_clr <= wdata_i[0 +: NUM_IRQ];
          ctl_o.sel     <= ptr_sel_e'(wdata_i[5:4]);
        end
        RG_BASE:   base_o   <= wdata_i[AW-1:0];
        RG_LAST:   last_o   <= wdata_i[AW-1:0];
        RG_PERIOD: period_o <= wdata_i[CNT_W-1:0];
        RG_INIT: begin
          init_o           <= wdata_i[AW-1:0];
          ctl_o.init_valid <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (idx)
      RG_CTRL_A: rdata_o = DW'(ctl_o.dma_en) | (DW'(ctl_o.irq_en) << 8)
                         | (DW'(ctl_o.thr_code) << 16);
      RG_CTRL_B: rdata_o = DW'(ctl_o.irq_clr) | (DW'(ctl_o.sel) << 4);
      RG_BASE:   rdata_o = DW'(base_o);
      RG_LAST:   rdata_o = DW'(last_o);
      RG_PERIOD: rdata_o = DW'(period_o);
      RG_INIT:   rdata_o = DW'(init_o);
      RG_STAT_A: rdata_o = DW'(status_i);
      RG_STAT_B: begin
        unique case (ctl_o.sel)
          PSEL_ADDR:  rdata_o = DW'(cur_addr_i);
          PSEL_COUNT: rdata_o = DW'(cur_cnt_i);
          PSEL_LEVEL: rdata_o = DW'(level_i);
          default:    rdata_o = '0;
        endcase
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ring_dma_addr.sv
module ring_dma_addr #(
  parameter int AW          = 32,
  parameter int BURST_BYTES = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          fire_i,
  input  logic          arm_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] last_i,
  input  logic [AW-1:0] init_i,
  input  logic          init_valid_i,
  output logic [AW-1:0] ptr_o,
  output logic          wrap_o,
  output logic          load_o
);
  localparam logic [AW-1:0] STEP = AW'(BURST_BYTES);

  logic pend_q;
  logic at_last;

  assign at_last = (ptr_o == last_i);
  assign wrap_o  = fire_i && at_last;
  assign load_o  = !en_i && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o  <= '0;
      pend_q <= 1'b1;
    end else begin
      if (load_o) begin
        ptr_o <= init_valid_i ? init_i : base_i;
      end else if (fire_i) begin
        ptr_o <= at_last ? base_i : ptr_o + STEP;
      end
      if (arm_i)       pend_q <= 1'b1;
      else if (load_o) pend_q <= 1'b0;
    end
  end

  AST_STEP_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !at_last) |=> (ptr_o == $past(ptr_o) + STEP)); // R2

  AST_WRAP_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && at_last) |=> (ptr_o == $past(base_i))); // R3
endmodule

// File: rtl/ring_dma_count.sv
module ring_dma_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             fire_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o
);
  logic [CNT_W:0] nxt;

  assign nxt    = {1'b0, cnt_o} + 1'b1;
  assign tick_o = fire_i && (period_i != '0) && (nxt >= {1'b0, period_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (clear_i) cnt_o <= '0;
    else if (tick_o)  cnt_o <= '0;
    else if (fire_i)  cnt_o <= nxt[CNT_W-1:0];
  end

  AST_PERIOD_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_o == '0)); // R4
endmodule

// File: rtl/ring_dma_irq.sv
module ring_dma_irq #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    status_o[i] <= 1'b0;
      else if (clr_i[i])              status_o[i] <= 1'b0;
      else if (ev_i[i] && en_i[i])    status_o[i] <= 1'b1;
    end
  end

  assign irq_o = |status_o;

  AST_CLR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((status_o & $past(clr_i)) == '0)); // R7

  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ev_i & ~en_i & ~status_o)) |=> ((status_o & ~$past(status_o) & ~$past(en_i)) == '0)); // R8
endmodule

// File: rtl/ring_dma_engine.sv
module ring_dma_engine
  import ring_dma_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int REG_AW      = 5,
  parameter int BURST_BYTES = 8,
  parameter int FIFO_BYTES  = 256,
  parameter int CNT_W       = 16,
  parameter int LVL_W       = $clog2(FIFO_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic [LVL_W-1:0]  fifo_level_i,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_gnt_i,
  output logic              irq_o
);
  localparam int BB_W  = $clog2(BURST_BYTES) + 1;
  localparam int THB_W = THR_W + BB_W + 1;
  localparam int CMP_W = (THB_W > LVL_W) ? THB_W : LVL_W;

  ctl_t               ctl;
  logic [AW-1:0]      base, last, init_a, ptr;
  logic [CNT_W-1:0]   period, cnt;
  logic [NUM_IRQ-1:0] status, events;
  logic               arm, wrap, load, tick, fire, req_q, below;
  logic [CMP_W-1:0]   thr_bytes;

  ring_dma_regs #(
    .AW(AW), .DW(DW), .REG_AW(REG_AW), .CNT_W(CNT_W), .LVL_W(LVL_W)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .cur_addr_i (ptr),
    .cur_cnt_i  (cnt),
    .status_i   (status),
    .level_i    (fifo_level_i),
    .ctl_o      (ctl),
    .base_o     (base),
    .last_o     (last),
    .init_o     (init_a),
    .period_o   (period),
    .arm_o      (arm)
  );

  // threshold code is bursts minus one
  assign thr_bytes = (CMP_W'(ctl.thr_code) + 1'b1) * CMP_W'(BURST_BYTES);
  assign below     = CMP_W'(fifo_level_i) <= thr_bytes;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 req_q <= 1'b0;
    else if (!ctl.dma_en)        req_q <= 1'b0;
    else if (req_q && mem_gnt_i) req_q <= 1'b0;
    else if (!req_q && below)    req_q <= 1'b1;
  end

  assign mem_req_o  = req_q && ctl.dma_en;
  assign fire       = mem_req_o && mem_gnt_i;
  assign mem_addr_o = ptr;

  ring_dma_addr #(.AW(AW), .BURST_BYTES(BURST_BYTES)) u_addr (
    .clk_i, .rst_ni,
    .en_i         (ctl.dma_en),
    .fire_i       (fire),
    .arm_i        (arm),
    .base_i       (base),
    .last_i       (last),
    .init_i       (init_a),
    .init_valid_i (ctl.init_valid),
    .ptr_o        (ptr),
    .wrap_o       (wrap),
    .load_o       (load)
  );

  ring_dma_count #(.CNT_W(CNT_W)) u_count (
    .clk_i, .rst_ni,
    .clear_i  (load),
    .fire_i   (fire),
    .period_i (period),
    .cnt_o    (cnt),
    .tick_o   (tick)
  );

  always_comb begin
    events           = '0;
    events[IRQ_PER]  = tick;
    events[IRQ_WRAP] = wrap;
  end

  ring_dma_irq #(.N(NUM_IRQ)) u_irq (
    .clk_i, .rst_ni,
    .ev_i     (events),
    .en_i     (ctl.irq_en),
    .clr_i    (ctl.irq_clr),
    .status_o (status),
    .irq_o    (irq_o)
  );

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i && $past(ctl.dma_en)) |=> (mem_req_o || !ctl.dma_en)); // R11

  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> $stable(mem_addr_o)); // R11

  AST_NO_MOVE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl.dma_en && !load && !arm) |=> $stable(mem_addr_o)); // R6
endmodule

// File: tb/ring_dma_engine_bench.sv
module ring_dma_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [8:0]  level = '0;
  logic        req;
  logic [31:0] maddr;
  logic        gnt = 1'b0;
  logic        irq;

  int vectors = 0;
  int fails   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ring_dma_engine u_ring_dma_engine (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .reg_we_i     (we),
    .reg_addr_i   (addr),
    .reg_wdata_i  (wdata),
    .reg_rdata_o  (rdata),
    .fifo_level_i (level),
    .mem_req_o    (req),
    .mem_addr_o   (maddr),
    .mem_gnt_i    (gnt),
    .irq_o        (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = {idx, 2'b00}; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    addr = {idx, 2'b00};
    #1;
    d = rdata;
  endtask

  task automatic wait_req(input string tag);
    logic seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (req) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
    chk(tag, 32'(seen), 32'd1);
  endtask

  task automatic grant(input string tag, input logic [31:0] exp_addr);
    wait_req(tag);
    chk(tag, maddr, exp_addr);
    gnt = 1'b1;
    @(negedge clk);
    gnt = 1'b0;
  endtask

  task automatic clr_pulse();
    wr(3'd1, 32'h3);
    wr(3'd1, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 req", 32'(req), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    rd(3'd6, d); chk("R1 status", d, 32'd0);
    rd(3'd7, d); chk("R1 pointer", d, 32'd0);
  endtask

  task automatic t_ring();
    logic [31:0] d;
    level = 9'd0;
    wr(3'd2, 32'h1000);
    wr(3'd3, 32'h1018);
    wr(3'd4, 32'd3);
    wr(3'd0, 32'h0001_0301);
    // R11: pending request held with stable address
    wait_req("R11 first req");
    d = maddr;
    @(negedge clk); @(negedge clk);
    chk("R11 req held", 32'(req), 32'd1);
    chk("R11 addr held", maddr, d);
    grant("R2 burst0", 32'h1000);
    grant("R2 burst1", 32'h1008);
    rd(3'd6, d); chk("R4 no early period", d, 32'd0);
    grant("R2 burst2", 32'h1010);
    rd(3'd6, d); chk("R4 period flag", d, 32'd1);
    chk("R8 irq follows status", 32'(irq), 32'd1);
    clr_pulse();
    rd(3'd6, d); chk("R7 cleared", d, 32'd0);
    grant("R3 last burst", 32'h1018);
    rd(3'd6, d); chk("R3 wrap flag", d, 32'd2);
    clr_pulse();
    grant("R3 back to base", 32'h1000);
    wr(3'd1, 32'h10);
    rd(3'd7, d); chk("R9 count select", d, 32'd2);
    wr(3'd1, 32'h20);
    rd(3'd7, d); chk("R9 level select", d, 32'd0);
    wr(3'd1, 32'h0);
    grant("R4 count restart", 32'h1008);
    rd(3'd6, d); chk("R4 second period", d, 32'd1);
    rd(3'd7, d); chk("R9 addr select", d, 32'h1010);
    clr_pulse();
  endtask

  task automatic t_pause();
    logic [31:0] d;
    wr(3'd0, 32'h0001_0300);
    repeat (5) @(negedge clk);
    chk("R6 req dropped", 32'(req), 32'd0);
    rd(3'd7, d); chk("R6 pointer kept", d, 32'h1010);
    wr(3'd0, 32'h0001_0301);
    grant("R6 resume addr", 32'h1010);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_thresh();
    wr(3'd2, 32'h2000);
    wr(3'd3, 32'h2038);
    level = 9'd16;
    wr(3'd0, 32'h0000_0001);
    repeat (6) @(negedge clk);
    chk("R5 code0 above", 32'(req), 32'd0);
    level = 9'd9;
    repeat (4) @(negedge clk);
    chk("R5 code0 at 9", 32'(req), 32'd0);
    level = 9'd8;
    grant("R5 code0 at 8", 32'h2000);
    level = 9'd33;
    wr(3'd0, 32'h0003_0001);
    repeat (4) @(negedge clk);
    chk("R5 code3 above", 32'(req), 32'd0);
    level = 9'd32;
    grant("R5 code3 at 32", 32'h2008);
    wr(3'd0, 32'h0);
    level = 9'd0;
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(3'd2, 32'h3000);
    wr(3'd3, 32'h3008);
    wr(3'd4, 32'd1);
    wr(3'd1, 32'h1);
    wr(3'd0, 32'h0000_0101);
    grant("R7 held a", 32'h3000);
    rd(3'd6, d); chk("R7 held a", d, 32'd0);
    grant("R7 held b", 32'h3008);
    rd(3'd6, d); chk("R8 wrap masked", d, 32'd0);
    chk("R7 irq low", 32'(irq), 32'd0);
    wr(3'd1, 32'h0);
    grant("R7 rearmed", 32'h3000);
    rd(3'd6, d); chk("R7 rearmed", d, 32'd1);
    grant("R8 wrap still masked", 32'h3008);
    rd(3'd6, d); chk("R8 wrap still masked", d, 32'd1);
    wr(3'd0, 32'h0);
    clr_pulse();
  endtask

  task automatic t_init();
    wr(3'd2, 32'h4000);
    wr(3'd3, 32'h4018);
    wr(3'd5, 32'h4010);
    wr(3'd0, 32'h0000_0001);
    grant("R10 init first", 32'h4010);
    grant("R10 init second", 32'h4018);
    grant("R10 wrap to base", 32'h4000);
    wr(3'd0, 32'h0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ring();
    t_pause();
    t_thresh();
    t_clear();
    t_init();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule